// File: doc/BRIEF.md
# Read-Window Receiver Power Gate

This controller saves power on a group of input receivers by driving two active-high disable buses. One bus switches the input buffers off, and the other switches on-die termination off. A read-enable bus, one bit per source, is OR-reduced into a single read indication. That indication opens a window during which both functions are switched on. The window starts a fixed two cycles after the read begins and stays open for a programmable idle count after the read ends. Everything runs in one clock domain, at the receive-word rate.

Each output bus has its own static source selection. The internal source takes the timing state machine, or a forced-on value when the group's termination enable bit is set. The external source passes a fabric-logic input straight through to the output. The single timing decision is copied to every lane of each bus that it drives.

Top module: `rx_power_gate`

## Requirements
- R1: While `rstN` is low, both output buses are all ones whatever the configuration. After release, with internal sources and `termEnable`=0, both buses stay all ones until a read occurs.
- R2: The read indication is the OR of all bits of `rdEn`, so any single bit opens a window. The timing result is copied to every lane of each bus driven by the state machine.
- R3: If `rdEn` is sampled non-zero at a rising edge while the gate is idle, the state-machine value stays 1 after that edge and becomes 0 after the next rising edge.
- R4: If `rdEn` is first sampled all-zero at edge F while the gate is on, the value stays 0 and returns to 1 at edge F+N, where N is `idleCount`.
- R5: If `idleCount` is 0, the value returns to 1 at the first edge that samples `rdEn` all-zero.
- R6: A non-zero `rdEn` sampled during the idle countdown cancels the countdown, and the value stays 0 without a pulse to 1.
- R7: A read that ends before the turn-on edge still drives the value to 0 at that edge. The value then returns to 1 at N+1 edges after the turn-on edge.
- R8: `idleCount` is captured when the countdown starts. Changes made during a countdown do not alter it.
- R9: Termination source: `odtSrcExt`=0 with `termEnable`=0 gives the state-machine value on `termDis`. `odtSrcExt`=0 with `termEnable`=1 gives all zeros. `odtSrcExt`=1 gives `fabricTermDis` unchanged.
- R10: Receiver source: `rxSrcExt`=0 with `termEnable`=0 gives the state-machine value on `rxDis`. `rxSrcExt`=0 with `termEnable`=1 gives all zeros. `rxSrcExt`=1 gives `fabricRxDis` unchanged, whatever `termEnable` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive-word-rate clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdEn | input | RDEN_W | Per-source read enables, OR-reduced |
| idleCount | input | IDLE_W | Cycles the window stays open after a read |
| odtSrcExt | input | 1 | 1 = termination-disable bus comes from fabric |
| rxSrcExt | input | 1 | 1 = receiver-disable bus comes from fabric |
| termEnable | input | 1 | Group termination enable; forces internal outputs on |
| fabricTermDis | input | LANES | Fabric value for termination disable |
| fabricRxDis | input | LANES | Fabric value for receiver disable |
| termDis | output | LANES | 1 = on-die termination off, per lane |
| rxDis | output | LANES | 1 = input buffer off, per lane |

## Verification
A wrong controller state shows up on the internally sourced buses as a turn-on edge one cycle early or late. It can also show as a window that closes too soon, or as a one-cycle pulse to 1 when a read resumes during the countdown. Each of these appears at the ports within one to two cycles of the read-enable change that exposes it. A counter that is loaded or decremented wrongly moves the closing edge by exactly the error. The bench therefore checks the outputs on both sides of every expected transition. A mux-select fault shows at once, because the bench puts distinct patterns on the fabric inputs.

// File: rtl/rpg_pkg.sv
package rpg_pkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_ARM,
    S_ON,
    S_HOLD
  } gateState_e;

  // strobes from control to datapath idle counter
  typedef struct packed {
    logic loadFull;   // load idleCount (read ended before turn-on)
    logic loadLess;   // load idleCount-1 (normal end of read)
    logic dec;        // count down one
  } cntStrobe_t;

endpackage

// File: rtl/rpg_ctrl.sv
module rpg_ctrl
  import rpg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdAny,
  input  logic       idleZero,
  input  logic       cntZero,
  output cntStrobe_t strobe,
  output logic       gateOff
);

  gateState_e state, stateNext;
  logic       gateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      gateOff <= 1'b1;
    end else begin
      state   <= stateNext;
      gateOff <= gateNext;
    end
  end

  always_comb begin
    stateNext = state;
    gateNext  = gateOff;
    strobe    = '0;
    case (state)
      S_IDLE: begin
        if (rdAny) stateNext = S_ARM;
      end
      S_ARM: begin
        gateNext = 1'b0;
        if (rdAny) begin
          stateNext = S_ON;
        end else begin
          stateNext       = S_HOLD;
          strobe.loadFull = 1'b1;
        end
      end
      S_ON: begin
        if (!rdAny) begin
          if (idleZero) begin
            stateNext = S_IDLE;
            gateNext  = 1'b1;
          end else begin
            stateNext       = S_HOLD;
            strobe.loadLess = 1'b1;
          end
        end
      end
      default: begin
        if (rdAny) begin
          stateNext = S_ON;
        end else if (cntZero) begin
          stateNext = S_IDLE;
          gateNext  = 1'b1;
        end else begin
          strobe.dec = 1'b1;
        end
      end
    endcase
  end

  // R3
  turn_on_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && rdAny) |=> ##1 !gateOff);

  // R3
  fall_needs_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(gateOff) |-> $past(rdAny, 2));

  // R4
  rise_needs_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gateOff) |-> !$past(rdAny));

  // R5
  idle_zero_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ON && !rdAny && idleZero) |=> gateOff);

  // R6
  cancel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HOLD && rdAny) |=> !gateOff);

endmodule

// File: rtl/rpg_datapath.sv
module rpg_datapath
  import rpg_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int RDEN_W = 4,
  parameter int IDLE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [RDEN_W-1:0] rdEn,
  input  logic [IDLE_W-1:0] idleCount,
  input  cntStrobe_t        strobe,
  input  logic              gateOff,
  input  logic              odtSrcExt,
  input  logic              rxSrcExt,
  input  logic              termEnable,
  input  logic [LANES-1:0]  fabricTermDis,
  input  logic [LANES-1:0]  fabricRxDis,
  output logic              rdAny,
  output logic              idleZero,
  output logic              cntZero,
  output logic [LANES-1:0]  termDis,
  output logic [LANES-1:0]  rxDis
);

  localparam logic [IDLE_W-1:0] CNT_ONE = IDLE_W'(1);

  logic [IDLE_W-1:0] idleCnt;
  logic [LANES-1:0]  smBus;

  assign rdAny    = |rdEn;
  assign idleZero = (idleCount == '0);
  assign cntZero  = (idleCnt == '0);
  assign smBus    = {LANES{gateOff}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (strobe.loadFull) begin
      idleCnt <= idleCount;
    end else if (strobe.loadLess) begin
      idleCnt <= idleCount - CNT_ONE;
    end else if (strobe.dec) begin
      idleCnt <= idleCnt - CNT_ONE;
    end
  end

  always_comb begin
    if (!rstN)          termDis = '1;
    else if (odtSrcExt) termDis = fabricTermDis;
    else if (termEnable) termDis = '0;
    else                termDis = smBus;
  end

  always_comb begin
    if (!rstN)           rxDis = '1;
    else if (rxSrcExt)   rxDis = fabricRxDis;
    else if (termEnable) rxDis = '0;
    else                 rxDis = smBus;
  end

  // R8
  count_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadFull |=> idleCnt == $past(idleCount));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dec |=> idleCnt == $past(idleCnt) - CNT_ONE);

  // R9
  term_forced_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!odtSrcExt && termEnable) |-> termDis == '0);

  // R10
  rx_forced_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rxSrcExt && termEnable) |-> rxDis == '0);

endmodule

// File: rtl/rx_power_gate.sv
module rx_power_gate
  import rpg_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int RDEN_W = 4,
  parameter int IDLE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [RDEN_W-1:0] rdEn,
  input  logic [IDLE_W-1:0] idleCount,
  input  logic              odtSrcExt,
  input  logic              rxSrcExt,
  input  logic              termEnable,
  input  logic [LANES-1:0]  fabricTermDis,
  input  logic [LANES-1:0]  fabricRxDis,
  output logic [LANES-1:0]  termDis,
  output logic [LANES-1:0]  rxDis
);

  cntStrobe_t strobe;
  logic       gateOff;
  logic       rdAny;
  logic       idleZero;
  logic       cntZero;

  rpg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rdAny    (rdAny),
    .idleZero (idleZero),
    .cntZero  (cntZero),
    .strobe   (strobe),
    .gateOff  (gateOff)
  );

  rpg_datapath #(
    .LANES  (LANES),
    .RDEN_W (RDEN_W),
    .IDLE_W (IDLE_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .rdEn          (rdEn),
    .idleCount     (idleCount),
    .strobe        (strobe),
    .gateOff       (gateOff),
    .odtSrcExt     (odtSrcExt),
    .rxSrcExt      (rxSrcExt),
    .termEnable    (termEnable),
    .fabricTermDis (fabricTermDis),
    .fabricRxDis   (fabricRxDis),
    .rdAny         (rdAny),
    .idleZero      (idleZero),
    .cntZero       (cntZero),
    .termDis       (termDis),
    .rxDis         (rxDis)
  );

endmodule

// File: tb/rx_power_gate_tb.sv
module rx_power_gate_tb;
  localparam int LANES  = 8;
  localparam int RDEN_W = 4;
  localparam int IDLE_W = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rstN;
  logic [RDEN_W-1:0] rdEn;
  logic [IDLE_W-1:0] idleCount;
  logic              odtSrcExt, rxSrcExt, termEnable;
  logic [LANES-1:0]  fabricTermDis, fabricRxDis;
  logic [LANES-1:0]  termDis, rxDis;

  int total = 0;
  int bad   = 0;

  rx_power_gate #(.LANES(LANES), .RDEN_W(RDEN_W), .IDLE_W(IDLE_W)) u_dut (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .idleCount(idleCount),
    .odtSrcExt(odtSrcExt), .rxSrcExt(rxSrcExt), .termEnable(termEnable),
    .fabricTermDis(fabricTermDis), .fabricRxDis(fabricRxDis),
    .termDis(termDis), .rxDis(rxDis)
  );

  task automatic chk(string req, string what, logic [LANES-1:0] act, logic [LANES-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic chkBoth(string req, string what, logic v);
    chk(req, {what, " termDis"}, termDis, {LANES{v}});
    chk(req, {what, " rxDis"}, rxDis, {LANES{v}});
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // read of highTicks cycles, idle count n; checks turn-on and close edges
  task automatic runWindow(string req, logic [RDEN_W-1:0] pat, int n, int highTicks);
    idleCount = IDLE_W'(n);
    rdEn = pat;
    tick(); chkBoth("R3", "before turn-on edge", 1'b1);
    tick(); chkBoth("R3", "after turn-on edge", 1'b0);
    tick(highTicks); chkBoth(req, "during read", 1'b0);
    rdEn = '0;
    if (n > 0) begin
      tick(n); chkBoth(req, "last idle cycle", 1'b0);
    end
    tick(); chkBoth(req, "window closed", 1'b1);
  endtask

  task automatic testReset();
    rstN = 1'b0; rdEn = '0; idleCount = '0;
    odtSrcExt = 1'b1; rxSrcExt = 1'b1; termEnable = 1'b1;
    fabricTermDis = 8'h00; fabricRxDis = 8'h00;
    tick(3);
    chkBoth("R1", "in reset, external sources", 1'b1);
    odtSrcExt = 1'b0; rxSrcExt = 1'b0; termEnable = 1'b0;
    #1 chkBoth("R1", "in reset, internal sources", 1'b1);
    tick(); rstN = 1'b1;
    tick(3); chkBoth("R1", "after release", 1'b1);
  endtask

  task automatic testShort();
    idleCount = IDLE_W'(2);
    rdEn = 4'b0010;
    tick(); chkBoth("R7", "short read armed", 1'b1);
    rdEn = '0;
    tick(); chkBoth("R7", "short read still turns on", 1'b0);
    tick(2); chkBoth("R7", "short read idle", 1'b0);
    tick(); chkBoth("R7", "short read closed", 1'b1);
  endtask

  task automatic testCancel();
    idleCount = IDLE_W'(4);
    rdEn = 4'b0001;
    tick(2); chkBoth("R6", "on", 1'b0);
    rdEn = '0;
    tick(2); chkBoth("R6", "countdown", 1'b0);
    rdEn = 4'b0100;
    for (int i = 0; i < 6; i++) begin
      tick(); chkBoth("R6", "resumed read, no pulse", 1'b0);
    end
    rdEn = '0;
    tick(4); chkBoth("R6", "second countdown", 1'b0);
    tick(); chkBoth("R6", "closed after cancel", 1'b1);
  endtask

  task automatic testLatch();
    idleCount = IDLE_W'(5);
    rdEn = 4'b1000;
    tick(3);
    rdEn = '0;
    tick(2);
    idleCount = IDLE_W'(0);
    tick(3); chkBoth("R8", "count kept after change", 1'b0);
    tick(); chkBoth("R8", "closed at captured count", 1'b1);
  endtask

  task automatic testSources();
    termEnable = 1'b1;
    #1 chk("R9", "internal forced", termDis, '0);
    chk("R10", "internal forced", rxDis, '0);
    odtSrcExt = 1'b1; fabricTermDis = 8'hA5;
    #1 chk("R9", "external pass", termDis, 8'hA5);
    chk("R10", "internal forced, term external", rxDis, '0);
    rxSrcExt = 1'b1; fabricRxDis = 8'h3C;
    #1 chk("R10", "external pass, termEnable=1", rxDis, 8'h3C);
    termEnable = 1'b0;
    #1 chk("R10", "external pass, termEnable=0", rxDis, 8'h3C);
    odtSrcExt = 1'b0;
    #1 chk("R9", "state machine idle", termDis, '1);
    idleCount = IDLE_W'(1);
    rdEn = 4'b0001;
    tick(2);
    chk("R9", "state machine on", termDis, '0);
    chk("R10", "fabric unaffected by read", rxDis, 8'h3C);
    rdEn = '0;
    tick(2);
    chk("R9", "state machine closed", termDis, '1);
    fabricTermDis = 8'h5A; odtSrcExt = 1'b1;
    #1 chk("R9", "external follows input", termDis, 8'h5A);
    odtSrcExt = 1'b0; rxSrcExt = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    testReset();
    runWindow("R4", 4'b0001, 3, 4);
    runWindow("R2", 4'b1000, 1, 2);
    runWindow("R5", 4'b0110, 0, 1);
    testShort();
    testCancel();
    testLatch();
    testSources();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule